// File: doc/BRIEF.md
# I2C Target Byte Store with Page Writes and Busy Polling

This block is a two-wire serial target that fronts a 256-byte store. It runs on a system clock. The SCL and SDA lines are synchronised and edge-detected inside the block. SDA is driven open-drain: when `sda_oe_o` is high, the pad pulls the line low.

The block recognises three families of address byte:
- the main array, which can be read and written;
- a read-only identity block, whose contents are computed from the address;
- a protection-command channel, which is forwarded to a separate policy block.

It supports byte and 16-byte page writes, current-address reads, random reads and sequential reads. It acknowledges every accepted byte on the ninth clock. After a committed write it holds a self-timed busy window, and during that window it answers no address, so a host can poll for completion.

Write protection is decided elsewhere. That decision reaches this block through two level inputs and one lock input.

Top module: `i2c_ee_target`

## Requirements
- R1: A falling SDA while SCL is high is a start. It restarts address reception from any state. A rising SDA while SCL is high is a stop. It returns the block to idle with SDA released.
- R2: The first byte after a start is laid out as {code[3:0], a[2:0], rw}, with rw=1 meaning read. Code 1010 selects the main array and code 1011 selects the identity block. Both are acknowledged only when a equals `strap_i`. Code 0110 selects the protection channel. Any other code, or a strap mismatch, gets no acknowledge, and the rest of the transfer is ignored.
- R3: An accepted byte is acknowledged by driving `sda_oe_o` high from the SCL fall after its eighth bit until the SCL fall that ends the ninth clock. After that, SDA is released.
- R4: A main-array write carries a word address and then up to 16 data bytes. Each byte goes to the current address. Only the low 4 address bits advance, so the address wraps within its 16-byte page.
- R5: Received data reaches the array only at a stop that arrives on a byte boundary. A repeated start, or a stop in the middle of a byte, discards the pending data. A stop with no data bytes starts no write cycle.
- R6: A committed write raises `busy_o` for BUSY_CYC system clocks. While `busy_o` is high, no address byte is acknowledged. Once it falls, addresses are acknowledged again.
- R7: Read data is sent MSB first and changes only after SCL falls. The address pointer advances by one per byte and wraps from 0xFF to 0x00. Sending continues while the host acknowledges and ends on a host no-acknowledge.
- R8: A random read is an address byte with rw=0 and a word address, then a repeated start and an address byte with rw=1. A read with no word address continues from the byte after the last one accessed.
- R9: Identity-block reads return ({a[3:0], a[7:4]} XOR ID_KEY), with ID_KEY=0x3C by default. Its word address is accepted. Its data bytes get no acknowledge, change nothing and start no busy window.
- R10: With `prot_all_i` high, no main-array byte is changed. With `prot_lo_i` high, bytes 0x00 to 0x7F are not changed. Blocked data bytes are still acknowledged, and the busy window still runs.
- R11: On the protection channel the three a bits form a command and are not compared with the straps. The address is acknowledged unless `prot_lock_i` is high. A write with at least one data byte pulses `prot_req_o` for one cycle at the stop, with `prot_cmd_o` equal to those bits, and starts the busy window. Reads on this channel return 0xFF.
- R12: The sequence start, nine clocks with SDA released, start, stop leaves the block idle from any state. Normal transfers then work.
- R13: After reset, SDA is released, `busy_o` is low, the array holds zeros and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull SDA low when high |
| strap_i | input | 3 | Board-strapped address bits |
| prot_lo_i | input | 1 | Block writes to lower half |
| prot_all_i | input | 1 | Block writes to whole array |
| prot_lock_i | input | 1 | Refuse protection-channel addresses |
| prot_req_o | output | 1 | One-cycle protection command strobe |
| prot_cmd_o | output | 3 | Command bits of the last protection write |
| busy_o | output | 1 | Internal write window active |

## Verification
The hardest conditions to reach are the ones where a bus event interrupts a transfer partway through. Examples are a stop a few bits into a data byte, a repeated start after data bytes, and the recovery sequence issued while a write byte is half sent. The bench host builds these by composing single-bit drive tasks with start and stop at arbitrary points. It then reads the targeted addresses back and checks `busy_o` to show that nothing was committed. Busy polling is reached by issuing address bytes right after the stop that ends a write, before the shortened busy window has run out.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int ADDR_W = 8;
  localparam int PAGE_W = 4;
  localparam int DATA_W = 8;

  localparam logic [3:0] CODE_MAIN = 4'b1010;
  localparam logic [3:0] CODE_EXT  = 4'b1011;
  localparam logic [3:0] CODE_PROT = 4'b0110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_ACK, ST_WADR, ST_WDAT, ST_RD, ST_RACK, ST_SKIP
  } st_e;

  typedef enum logic [1:0] {TG_MAIN, TG_EXT, TG_PROT} tgt_e;

  function automatic logic [DATA_W-1:0] ext_byte(input logic [ADDR_W-1:0] a,
                                                 input logic [DATA_W-1:0] key);
    return {a[3:0], a[7:4]} ^ key;
  endfunction
endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  assign scl_o   = scl_q[STAGES-1];
  assign sda_o   = sda_q[STAGES-1];
  assign scl_p   = scl_q[STAGES];
  assign sda_p   = sda_q[STAGES];
  assign start_o = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o  = scl_o & scl_p & ~sda_p & sda_o;
  assign rise_o  = scl_o & ~scl_p;
  assign fall_o  = ~scl_o & scl_p;
endmodule

// File: rtl/i2c_ee_busy.sv
module i2c_ee_busy #(
  parameter int CYC = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CW'(CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = cnt_q != '0;

  p_busy_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store
  import i2c_ee_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_KEY = 8'h3C
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     wr_en_i,
  input  logic [PAGE_W-1:0]        wr_idx_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  input  logic                     prot_lo_i,
  input  logic                     prot_all_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  input  logic                     rd_ext_i,
  output logic [DATA_W-1:0]        rd_data_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] buf_q [PAGE_N];
  logic [PAGE_N-1:0] mask_q;
  logic              page_blk;

  // page MSB decides lower/upper half for the whole page
  assign page_blk = prot_all_i | (prot_lo_i & ~page_i[ADDR_W-PAGE_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      for (int i = 0; i < PAGE_N; i++) buf_q[i] <= '0;
    end else if (clr_i || commit_i) begin
      mask_q <= '0;
    end else if (wr_en_i) begin
      buf_q[wr_idx_i]  <= wr_data_i;
      mask_q[wr_idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (commit_i && !page_blk) begin
      for (int i = 0; i < PAGE_N; i++)
        if (mask_q[i]) mem_q[{page_i, PAGE_W'(i)}] <= buf_q[i];
    end
  end

  assign rd_data_o = rd_ext_i ? ext_byte(rd_addr_i, ID_KEY) : mem_q[rd_addr_i];
endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target
  import i2c_ee_pkg::*;
#(
  parameter int                BUSY_CYC    = 5000,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ID_KEY      = 8'h3C
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] strap_i,
  input  logic       prot_lo_i,
  input  logic       prot_all_i,
  input  logic       prot_lock_i,
  output logic       prot_req_o,
  output logic [2:0] prot_cmd_o,
  output logic       busy_o
);
  logic scl_s, sda_s, start_ev, stop_ev, rise_ev, fall_ev;
  logic busy, go_busy, commit, wr_en, byte_done, load_now, dev_hit;
  logic [DATA_W-1:0] st_rd, rd_byte;
  tgt_e dev_tgt;

  st_e               st_q, nxt_q;
  tgt_e              tgt_q;
  logic [DATA_W-1:0] sh_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [3:0]        bit_q;
  logic              oe_q, host_ack_q, wr_any_q, req_q;
  logic [2:0]        cmd_q;

  i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start_ev), .stop_o(stop_ev),
    .rise_o(rise_ev), .fall_o(fall_ev)
  );

  i2c_ee_busy #(.CYC(BUSY_CYC)) u_busy (
    .clk_i, .rst_ni, .start_i(go_busy), .busy_o(busy)
  );

  i2c_ee_store #(.ID_KEY(ID_KEY)) u_store (
    .clk_i, .rst_ni, .clr_i(start_ev), .wr_en_i(wr_en),
    .wr_idx_i(ptr_q[PAGE_W-1:0]), .wr_data_i(sh_q), .commit_i(commit),
    .page_i(ptr_q[ADDR_W-1:PAGE_W]), .prot_lo_i, .prot_all_i,
    .rd_addr_i(ptr_q), .rd_ext_i(tgt_q == TG_EXT), .rd_data_o(st_rd)
  );

  assign byte_done = fall_ev && bit_q == 4'd8;
  assign rd_byte   = (tgt_q == TG_PROT) ? '1 : st_rd;
  assign wr_en     = st_q == ST_WDAT && byte_done && tgt_q == TG_MAIN;
  // stop's own SCL rise is counted, so a boundary stop sees at most one bit
  assign go_busy   = stop_ev && st_q == ST_WDAT && bit_q <= 4'd1 && wr_any_q;
  assign commit    = go_busy && tgt_q == TG_MAIN;
  assign load_now  = fall_ev && ((st_q == ST_ACK && nxt_q == ST_RD) ||
                                 (st_q == ST_RACK && host_ack_q));

  always_comb begin
    dev_tgt = TG_MAIN;
    dev_hit = 1'b0;
    case (sh_q[7:4])
      CODE_MAIN: dev_hit = sh_q[3:1] == strap_i;
      CODE_EXT:  begin dev_tgt = TG_EXT;  dev_hit = sh_q[3:1] == strap_i; end
      CODE_PROT: begin dev_tgt = TG_PROT; dev_hit = !prot_lock_i; end
      default:   dev_hit = 1'b0;
    endcase
    if (busy) dev_hit = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; nxt_q <= ST_IDLE; tgt_q <= TG_MAIN;
      sh_q <= '0; ptr_q <= '0; bit_q <= '0;
      oe_q <= 1'b0; host_ack_q <= 1'b0; wr_any_q <= 1'b0;
      req_q <= 1'b0; cmd_q <= '0;
    end else begin
      req_q <= 1'b0;
      if (stop_ev) begin
        st_q <= ST_IDLE; oe_q <= 1'b0; bit_q <= '0;
        if (go_busy && tgt_q == TG_PROT) req_q <= 1'b1;
      end else if (start_ev) begin
        st_q <= ST_DEV; oe_q <= 1'b0; bit_q <= '0; wr_any_q <= 1'b0;
      end else if (load_now) begin
        sh_q  <= rd_byte;
        oe_q  <= ~rd_byte[7];
        bit_q <= '0;
        st_q  <= ST_RD;
        if (tgt_q != TG_PROT) ptr_q <= ptr_q + 1'b1;
      end else begin
        case (st_q)
          ST_DEV, ST_WADR, ST_WDAT: begin
            if (rise_ev && bit_q != 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_s};
              bit_q <= bit_q + 4'd1;
            end else if (byte_done) begin
              bit_q <= '0;
              if (st_q == ST_DEV) begin
                if (dev_hit) begin
                  oe_q <= 1'b1; st_q <= ST_ACK; tgt_q <= dev_tgt;
                  nxt_q <= sh_q[0] ? ST_RD : ST_WADR; cmd_q <= sh_q[3:1];
                end else st_q <= ST_SKIP;
              end else if (st_q == ST_WADR) begin
                oe_q <= 1'b1; st_q <= ST_ACK; nxt_q <= ST_WDAT; ptr_q <= sh_q;
              end else if (tgt_q == TG_EXT) begin
                st_q <= ST_SKIP;
              end else begin
                oe_q <= 1'b1; st_q <= ST_ACK; nxt_q <= ST_WDAT; wr_any_q <= 1'b1;
                ptr_q[PAGE_W-1:0] <= ptr_q[PAGE_W-1:0] + 1'b1;
              end
            end
          end
          ST_ACK: if (fall_ev) begin oe_q <= 1'b0; st_q <= nxt_q; end
          ST_RD: if (fall_ev) begin
            if (bit_q == 4'd7) begin
              oe_q <= 1'b0; st_q <= ST_RACK; bit_q <= '0;
            end else begin
              sh_q <= {sh_q[6:0], 1'b0}; oe_q <= ~sh_q[6]; bit_q <= bit_q + 4'd1;
            end
          end
          ST_RACK: begin
            if (rise_ev)      host_ack_q <= ~sda_s;
            else if (fall_ev) st_q <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign busy_o     = busy;
  assign prot_req_o = req_q;
  assign prot_cmd_o = cmd_q;

  p_oe_scl_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);
  p_stop_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ev |=> (st_q == ST_IDLE && !sda_oe_o));
  p_busy_nack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DEV && byte_done && busy_o) |=> (!sda_oe_o && st_q == ST_SKIP));
  p_strap_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DEV && byte_done && sh_q[7:4] == CODE_MAIN && sh_q[3:1] != strap_i)
    |=> (!sda_oe_o && st_q == ST_SKIP));
  p_req_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_req_o |-> busy_o);
endmodule

// File: tb/sim_i2c_ee_target.sv
module sim_i2c_ee_target;
  localparam int CLK_PERIOD = 10;
  localparam int QT         = 10;
  localparam int BUSY       = 2000;
  localparam logic [2:0] S  = 3'b101;
  localparam logic [3:0] C_MAIN = 4'b1010, C_EXT = 4'b1011, C_PROT = 4'b0110;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1;
  logic prot_lo = 1'b0, prot_all = 1'b0, prot_lock = 1'b0;
  logic sda_oe, prot_req, busy;
  logic [2:0] prot_cmd, req_cmd = '0;
  int req_cnt = 0;
  wire sda_line = sda_h & ~sda_oe;

  int n_run = 0, n_fail = 0;
  int exp_q[$], obs_q[$];
  string tag_q[$];
  logic [7:0] mdl [256];
  logic [7:0] mptr;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_ee_target #(.BUSY_CYC(BUSY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .strap_i(S), .prot_lo_i(prot_lo), .prot_all_i(prot_all), .prot_lock_i(prot_lock),
    .prot_req_o(prot_req), .prot_cmd_o(prot_cmd), .busy_o(busy)
  );

  always @(posedge clk) if (prot_req) begin req_cnt++; req_cmd = prot_cmd; end

  // monitor: pops observations and compares with expected queue
  initial forever begin
    int o, e;
    string t;
    wait (obs_q.size() != 0);
    o = obs_q.pop_front();
    n_run++;
    if (exp_q.size() == 0) begin
      n_fail++; $display("FAIL scoreboard: got %0h expected nothing", o);
    end else begin
      e = exp_q.pop_front(); t = tag_q.pop_front();
      if (o !== e) begin n_fail++; $display("FAIL %s: got %0h expected %0h", t, o, e); end
    end
  end

  function automatic logic [7:0] dev(input logic [3:0] c, input logic [2:0] a, input logic rw);
    return {c, a, rw};
  endfunction
  function automatic logic [7:0] ext_v(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'h3C;
  endfunction
  function automatic bit blocked(input logic [7:0] a);
    return prot_all || (prot_lo && !a[7]);
  endfunction

  task automatic expect_v(input string t, input int v); exp_q.push_back(v); tag_q.push_back(t); endtask
  task automatic chk(input string t, input int got, input int e); expect_v(t, e); obs_q.push_back(got); endtask
  task automatic q(); repeat (QT) @(negedge clk); endtask
  task automatic bit_o(input logic b); sda_h = b; q(); scl = 1; q(); q(); scl = 0; q(); endtask
  task automatic bit_i(output logic b); sda_h = 1; q(); scl = 1; q(); b = sda_line; q(); scl = 0; q(); endtask
  task automatic i2c_start(); sda_h = 1; q(); scl = 1; q(); sda_h = 0; q(); scl = 0; q(); endtask
  task automatic i2c_stop(); sda_h = 0; q(); scl = 1; q(); sda_h = 1; q(); endtask

  task automatic wbyte(input logic [7:0] d, input int ack_e, input string t);
    logic a;
    for (int i = 7; i >= 0; i--) bit_o(d[i]);
    bit_i(a);
    chk(t, a, ack_e);
  endtask

  task automatic rbyte(input logic last, input logic [7:0] e, input string t);
    logic [7:0] d;
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_i(b); d[i] = b; end
    chk(t, d, e);
    bit_o(last);
  endtask

  task automatic wait_busy(); repeat (BUSY + 20) @(negedge clk); endtask

  task automatic do_write(input logic [3:0] c, input logic [7:0] a, input int n,
                          input logic [7:0] d0, input string t);
    i2c_start();
    wbyte(dev(c, S, 0), 0, t);
    wbyte(a, 0, t);
    mptr = a;
    for (int k = 0; k < n; k++) begin
      wbyte(d0 + 8'(k), (c == C_EXT) ? 1 : 0, t);
      if (c == C_MAIN) begin
        if (!blocked(mptr)) mdl[mptr] = d0 + 8'(k);
        mptr = {mptr[7:4], mptr[3:0] + 4'd1};
      end
    end
    i2c_stop();
    chk({t, " busy"}, busy, (n > 0 && c != C_EXT) ? 1 : 0);
    if (n > 0 && c != C_EXT) wait_busy();
  endtask

  task automatic do_read(input bit rnd, input logic [3:0] c, input logic [7:0] a,
                         input int n, input string t);
    i2c_start();
    if (rnd) begin
      wbyte(dev(c, S, 0), 0, t);
      wbyte(a, 0, t);
      mptr = a;
      i2c_start();
    end
    wbyte(dev(c, S, 1), 0, t);
    for (int k = 0; k < n; k++) begin
      rbyte(k == n - 1, (c == C_EXT) ? ext_v(mptr) : mdl[mptr], t);
      mptr = mptr + 8'd1;
    end
    i2c_stop();
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_fail++; $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    mptr = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R13 sda released", sda_oe, 0);
    chk("R13 busy low", busy, 0);
    do_read(0, C_MAIN, 8'h00, 1, "R13 reset pointer");

    do_write(C_MAIN, 8'h10, 1, 8'h5A, "R4 byte write");

    // R6 busy polling
    i2c_start(); wbyte(dev(C_MAIN, S, 0), 0, "R6"); wbyte(8'h33, 0, "R6");
    wbyte(8'hC3, 0, "R6"); i2c_stop();
    mdl[8'h33] = 8'hC3;
    chk("R6 busy after stop", busy, 1);
    i2c_start(); wbyte(dev(C_MAIN, S, 0), 1, "R6 poll nack"); i2c_stop();
    i2c_start(); wbyte(dev(C_EXT, S, 1), 1, "R6 poll nack ext"); i2c_stop();
    wait_busy();
    chk("R6 busy ended", busy, 0);
    i2c_start(); wbyte(dev(C_MAIN, S, 0), 0, "R6 ack after busy"); i2c_stop();
    chk("R5 no data no busy", busy, 0);

    do_read(1, C_MAIN, 8'h10, 1, "R8 random read");
    do_read(0, C_MAIN, 8'h00, 1, "R8 current read");
    do_read(1, C_MAIN, 8'h33, 2, "R7 sequential");

    do_write(C_MAIN, 8'h2E, 4, 8'h81, "R4 page write");
    do_read(1, C_MAIN, 8'h2E, 2, "R4 page head");
    do_read(1, C_MAIN, 8'h20, 3, "R4 page wrap");

    do_write(C_MAIN, 8'hFF, 1, 8'h77, "R7 setup");
    do_write(C_MAIN, 8'h00, 1, 8'h66, "R7 setup");
    do_read(1, C_MAIN, 8'hFE, 3, "R7 pointer wrap");

    i2c_start(); wbyte(dev(C_MAIN, ~S, 1), 1, "R2 strap mismatch"); i2c_stop();
    i2c_start(); wbyte(dev(4'b1100, S, 1), 1, "R2 unknown code"); i2c_stop();
    chk("R1 released after stop", sda_oe, 0);

    do_read(1, C_EXT, 8'h80, 3, "R9 ext read");
    do_write(C_EXT, 8'h90, 1, 8'h55, "R9 ext write nack");
    do_read(1, C_EXT, 8'h90, 1, "R9 ext unchanged");

    prot_lo = 1;
    do_write(C_MAIN, 8'h05, 1, 8'h11, "R10 lower blocked");
    do_write(C_MAIN, 8'h85, 1, 8'h22, "R10 upper open");
    do_read(1, C_MAIN, 8'h05, 1, "R10 lower unchanged");
    do_read(1, C_MAIN, 8'h85, 1, "R10 upper written");
    prot_lo = 0; prot_all = 1;
    do_write(C_MAIN, 8'h85, 1, 8'h99, "R10 all blocked");
    do_read(1, C_MAIN, 8'h85, 1, "R10 all unchanged");
    prot_all = 0;

    i2c_start(); wbyte(dev(C_PROT, 3'b011, 0), 0, "R11 prot addr");
    wbyte(8'h00, 0, "R11"); wbyte(8'h00, 0, "R11"); i2c_stop();
    chk("R11 busy", busy, 1);
    wait_busy();
    chk("R11 req count", req_cnt, 1);
    chk("R11 req cmd", req_cmd, 3'b011);
    i2c_start(); wbyte(dev(C_PROT, 3'b011, 1), 0, "R11 prot read");
    rbyte(1, 8'hFF, "R11 prot read ones"); i2c_stop();
    prot_lock = 1;
    i2c_start(); wbyte(dev(C_PROT, 3'b011, 0), 1, "R11 locked nack"); i2c_stop();
    prot_lock = 0;

    // R5 stop inside a data byte
    i2c_start(); wbyte(dev(C_MAIN, S, 0), 0, "R5"); wbyte(8'h40, 0, "R5");
    wbyte(8'hEE, 0, "R5");
    for (int i = 0; i < 4; i++) bit_o(1'b1);
    i2c_stop();
    chk("R5 mid-byte stop no busy", busy, 0);
    chk("R1 mid-byte stop release", sda_oe, 0);
    do_read(1, C_MAIN, 8'h40, 1, "R5 mid-byte stop discard");
    // R5 repeated start after data
    i2c_start(); wbyte(dev(C_MAIN, S, 0), 0, "R5"); wbyte(8'h41, 0, "R5");
    wbyte(8'hDD, 0, "R5");
    i2c_start(); wbyte(dev(C_MAIN, S, 1), 0, "R5 restart read");
    rbyte(1, mdl[8'h42], "R5 restart read data"); i2c_stop();
    chk("R5 restart no busy", busy, 0);
    do_read(1, C_MAIN, 8'h41, 1, "R5 restart discard");

    // R12 recovery from a half-sent write byte
    i2c_start(); wbyte(dev(C_MAIN, S, 0), 0, "R12"); wbyte(8'h50, 0, "R12");
    for (int i = 0; i < 3; i++) bit_o(1'b0);
    i2c_start();
    for (int i = 0; i < 9; i++) bit_o(1'b1);
    i2c_start(); i2c_stop();
    chk("R12 idle released", sda_oe, 0);
    chk("R12 no busy", busy, 0);
    do_read(1, C_MAIN, 8'h10, 1, "R12 normal after recovery");

    repeat (20) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule